// File: doc/BRIEF.md
# Peripheral Clock Gate, Source Select and Divider Slot

This block is a single slot of a peripheral clock controller. A 32-bit control word, written and read through a plain register port, picks one of up to seven parent clock-enable inputs. It can divide the chosen stream by an integer ratio from 1 to 8, or by a fractional ratio that keeps two pulses out of every (div+1). A gate bit switches the resulting enable stream on and off. Every clock is modelled as a one-cycle enable pulse in the single system clock domain, so the output is also an enable pulse train.

Another agent can claim the slot through the `claim_i` input, which sets the in-use flag. While the gate is on, or while the slot is claimed, the source and divider fields are frozen. While the slot is claimed, the gate bit is also frozen. A write that tries to change a frozen field leaves it as it was and sets a sticky error flag. A parameter says whether the slot is present. An absent slot accepts no change at all.

Top module: `pclk_slot`

## Requirements
- R1: After reset, `rd_data` reads only the present flag at bit 31 (0x8000_0000 when PRESENT=1). `clk_en_o` and `running_o` are low.
- R2: The source field is at bits 26:24. The value 0 gives no output pulses. A value k from 1 to 7 passes parent input `src_en_i[k-1]` and ignores every other input.
- R3: The divide field is at bits 2:0 and holds the ratio minus one. With the fraction bit clear, the gated output gives one pulse for every (div+1) parent pulses. The first pulse comes on the (div+1)-th parent pulse after the gate turns on, because the divider restarts each time the gate goes from off to on.
- R4: The fraction bit is at bit 3. When it is set, the output gives two pulses for every (div+1) parent pulses, with at most one output pulse per parent pulse. For div=2 the pattern is 0,1,1 and repeats. For div=3 the pattern is 0,1,0,1.
- R5: A write that would set the fraction bit with a divide field of 0 leaves the source, fraction and divide fields unchanged and sets the error flag.
- R6: A write to the source, fraction or divide fields changes them only when the slot is present, the in-use flag (bit 30) is clear and the gate bit (bit 29) is clear. Any other change attempt sets the error flag.
- R7: The gate bit changes only when the slot is present and not in use. A rejected attempt to change it sets the error flag.
- R8: With PRESENT=0, bit 31 reads 0 and no write changes any field.
- R9: The in-use flag follows `claim_i` one cycle later. `running_o` is high exactly when the in-use flag or the gate bit is set.
- R10: The error flag at bit 8 is sticky. A later accepted write leaves it set. A write with bit 8 at 1 clears it, unless that same write is rejected.
- R11: `clk_en_o` is high only in the cycle after a parent pulse that arrived while the gate was set and the source field was nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word |
| claim_i | input | 1 | Another agent holds the slot (drives the in-use flag) |
| src_en_i | input | NUM_SRC | Parent clock-enable pulses |
| clk_en_o | output | 1 | Gated and divided clock-enable pulse |
| running_o | output | 1 | Clock counts as running (in use or gated on) |

## Verification
The bench targets the divider restart. A design that keeps the count when the gate is turned off and on again would give its first pulse early. It checks the fractional spacing for two ratios. A wrong accumulator would bunch pulses together or drop one. It tries to change the source, divider and gate while they are locked, and tries the invalid fraction-with-ratio-one write. A design that leaks any of these would show changed read-back values and no error flag. It also checks that an absent slot keeps every field at zero, and that an error flag cleared on a rejected write stays set.

// File: rtl/pclk_slot_pkg.sv
package pclk_slot_pkg;
  localparam int CTRL_W      = 32;
  localparam int SEL_W       = 3;
  localparam int DIV_W       = 3;
  localparam int BIT_PRESENT = 31;
  localparam int BIT_INUSE   = 30;
  localparam int BIT_GATE    = 29;
  localparam int SEL_LSB     = 24;
  localparam int BIT_ERR     = 8;
  localparam int BIT_FRAC    = 3;
  localparam int DIV_LSB     = 0;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             frac;
    logic [DIV_W-1:0] div;
  } slot_cfg_t;
endpackage

// File: rtl/pclk_slot_regs.sv
module pclk_slot_regs
  import pclk_slot_pkg::*;
#(
  parameter int PRESENT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              claim_i,
  output slot_cfg_t         cfg_o,
  output logic              gate_o,
  output logic              inuse_o,
  output logic              err_o
);
  localparam logic PRES = (PRESENT != 0);

  slot_cfg_t cfg_q, wr_cfg;
  logic      gate_q, inuse_q, err_q;
  logic      cfg_diff, cfg_bad, cfg_open, gate_diff, gate_open, reject;
  logic      unused_bits;

  assign unused_bits = ^{wr_data[BIT_PRESENT], wr_data[BIT_INUSE],
                         wr_data[BIT_GATE-1:SEL_LSB+SEL_W],
                         wr_data[SEL_LSB-1:BIT_ERR+1],
                         wr_data[BIT_ERR-1:BIT_FRAC+1]};

  always_comb begin
    wr_cfg.sel  = wr_data[SEL_LSB +: SEL_W];
    wr_cfg.frac = wr_data[BIT_FRAC];
    wr_cfg.div  = wr_data[DIV_LSB +: DIV_W];
    cfg_diff    = (wr_cfg != cfg_q);
    cfg_bad     = wr_cfg.frac && (wr_cfg.div == '0);
    cfg_open    = PRES && !inuse_q && !gate_q && !cfg_bad;
    gate_diff   = (wr_data[BIT_GATE] != gate_q);
    gate_open   = PRES && !inuse_q;
    reject      = (cfg_diff && !cfg_open) || (gate_diff && !gate_open);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      gate_q  <= 1'b0;
      inuse_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      inuse_q <= claim_i;
      if (wr_en) begin
        if (cfg_diff && cfg_open)
          cfg_q <= wr_cfg;
        if (gate_diff && gate_open)
          gate_q <= wr_data[BIT_GATE];
        err_q <= reject || (err_q && !wr_data[BIT_ERR]);
      end
    end
  end

  assign cfg_o   = cfg_q;
  assign gate_o  = gate_q;
  assign inuse_o = inuse_q;
  assign err_o   = err_q;
endmodule

// File: rtl/pclk_slot_mux.sv
module pclk_slot_mux #(
  parameter int NUM_SRC = 7,
  parameter int SEL_W   = 3
) (
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [NUM_SRC-1:0] src_en_i,
  output logic               pick_o
);
  localparam int SLOTS = 2 ** SEL_W;

  logic [SLOTS-1:0] ext;

  for (genvar gi = 0; gi < SLOTS; gi++) begin : g_ext
    if (gi == 0) begin : g_off
      assign ext[gi] = 1'b0;
    end else if (gi <= NUM_SRC) begin : g_src
      assign ext[gi] = src_en_i[gi-1];
    end else begin : g_pad
      assign ext[gi] = 1'b0;
    end
  end

  assign pick_o = ext[sel_i];
endmodule

// File: rtl/pclk_slot_div.sv
module pclk_slot_div #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             frac_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             en_o
);
  localparam int ACC_W = DIV_W + 1;

  logic [ACC_W-1:0] acc_q, period, step, sum;
  logic             hit;

  always_comb begin
    period = {1'b0, div_i} + ACC_W'(1);
    step   = frac_i ? ACC_W'(2) : ACC_W'(1);
    sum    = acc_q + step;
    hit    = (sum >= period);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      en_o  <= 1'b0;
    end else begin
      en_o <= run_i && tick_i && hit;
      if (!run_i)
        acc_q <= '0;
      else if (tick_i)
        acc_q <= hit ? (sum - period) : sum;
    end
  end
endmodule

// File: rtl/pclk_slot.sv
module pclk_slot
  import pclk_slot_pkg::*;
#(
  parameter int NUM_SRC = 7,
  parameter int PRESENT = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [31:0]        wr_data,
  output logic [31:0]        rd_data,
  input  logic               claim_i,
  input  logic [NUM_SRC-1:0] src_en_i,
  output logic               clk_en_o,
  output logic               running_o
);
  localparam logic PRES = (PRESENT != 0);

  slot_cfg_t cfg;
  logic      gate, inuse, err, pick, run;

  pclk_slot_regs #(.PRESENT(PRESENT)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .claim_i(claim_i), .cfg_o(cfg), .gate_o(gate), .inuse_o(inuse), .err_o(err)
  );

  pclk_slot_mux #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_mux (
    .sel_i(cfg.sel), .src_en_i(src_en_i), .pick_o(pick)
  );

  assign run = gate && (cfg.sel != '0);

  pclk_slot_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run_i(run), .tick_i(pick),
    .frac_i(cfg.frac), .div_i(cfg.div), .en_o(clk_en_o)
  );

  always_comb begin
    rd_data                        = '0;
    rd_data[BIT_PRESENT]           = PRES;
    rd_data[BIT_INUSE]             = inuse;
    rd_data[BIT_GATE]              = gate;
    rd_data[SEL_LSB +: SEL_W]      = cfg.sel;
    rd_data[BIT_ERR]               = err;
    rd_data[BIT_FRAC]              = cfg.frac;
    rd_data[DIV_LSB +: DIV_W]      = cfg.div;
  end

  assign running_o = inuse || gate;
endmodule

// File: rtl/pclk_slot_chk.sv
module pclk_slot_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       err_clr,
  input logic       inuse,
  input logic       gate,
  input logic [2:0] sel,
  input logic [3:0] cfg_lo,
  input logic       err,
  input logic       clk_en_o,
  input logic       running_o
);
  p_cfg_lock_r6: assert property (@(posedge clk) disable iff (rst)
    (gate || inuse) |=> ($stable(sel) && $stable(cfg_lo)));

  p_gate_lock_r7: assert property (@(posedge clk) disable iff (rst)
    inuse |=> $stable(gate));

  p_out_gated_r11: assert property (@(posedge clk) disable iff (rst)
    clk_en_o |-> ($past(gate) && ($past(sel) != 3'd0)));

  p_src_off_r2: assert property (@(posedge clk) disable iff (rst)
    (sel == 3'd0) |=> !clk_en_o);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (err && !(wr_en && err_clr)) |=> err);

  p_running_r9: assert property (@(posedge clk) disable iff (rst)
    running_o == (inuse || gate));

  always_comb begin
    if (!rst) begin
      p_no_bad_combo_r5: assert (!(cfg_lo[3] && cfg_lo[2:0] == 3'd0));
    end
  end
endmodule

bind pclk_slot pclk_slot_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .err_clr(wr_data[8]),
  .inuse(rd_data[30]), .gate(rd_data[29]), .sel(rd_data[26:24]),
  .cfg_lo(rd_data[3:0]), .err(rd_data[8]),
  .clk_en_o(clk_en_o), .running_o(running_o)
);

// File: tb/test_pclk_slot.sv
module test_pclk_slot;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 7;
  localparam logic [31:0] PBIT = 32'h8000_0000;
  localparam logic [31:0] EBIT = 32'h0000_0100;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wr_en = 1'b0;
  logic [31:0]     wr_data = '0;
  logic            claim = 1'b0;
  logic [NSRC-1:0] src = '0;
  logic [31:0]     rd, rd_np;
  logic            clk_en, running, clk_en_np, running_np;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pclk_slot #(.NUM_SRC(NSRC), .PRESENT(1)) i_pclk_slot (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd),
    .claim_i(claim), .src_en_i(src), .clk_en_o(clk_en), .running_o(running)
  );

  pclk_slot #(.NUM_SRC(NSRC), .PRESENT(0)) i_pclk_slot_np (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_np),
    .claim_i(1'b0), .src_en_i(src), .clk_en_o(clk_en_np), .running_o(running_np)
  );

  function automatic logic [31:0] mk(input logic g, input logic [2:0] s,
                                     input logic f, input logic [2:0] d,
                                     input logic clr);
    return (32'(g) << 29) | (32'(s) << 24) | (32'(clr) << 8) | (32'(f) << 3) | 32'(d);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  task automatic pulse(input logic [NSRC-1:0] m, input logic exp, input string tag);
    @(negedge clk);
    src = m;
    @(negedge clk);
    src = '0;
    chk(tag, 32'(clk_en), 32'(exp));
  endtask

  task automatic t_reset;
    chk("R1 reset word", rd, PBIT);
    chk("R1 reset clk_en", 32'(clk_en), 0);
    chk("R1 reset running", 32'(running), 0);
  endtask

  task automatic t_source;
    wr(mk(0, 3'd2, 0, 3'd0, 0));
    chk("R2 select readback", rd, PBIT | mk(0, 3'd2, 0, 3'd0, 0));
    wr(mk(1, 3'd2, 0, 3'd0, 0));
    pulse(7'b0000001, 1'b0, "R2 other input ignored");
    pulse(7'b0000010, 1'b1, "R2 selected input 1 passes");
    wr(mk(0, 3'd2, 0, 3'd0, 0));
    wr(mk(0, 3'd7, 0, 3'd0, 0));
    wr(mk(1, 3'd7, 0, 3'd0, 0));
    pulse(7'b1000000, 1'b1, "R2 selected input 6 passes");
    wr(mk(0, 3'd7, 0, 3'd0, 0));
    wr(mk(0, 3'd0, 0, 3'd0, 0));
    wr(mk(1, 3'd0, 0, 3'd0, 0));
    pulse(7'h7F, 1'b0, "R2 source off gives nothing");
    wr(mk(0, 3'd0, 0, 3'd0, 0));
    chk("R2 no error from legal writes", rd & EBIT, 0);
  endtask

  task automatic t_divide;
    logic exp6 [6] = '{0, 0, 1, 0, 0, 1};
    wr(mk(0, 3'd1, 0, 3'd2, 0));
    pulse(7'b0000001, 1'b0, "R11 gate off blocks");
    wr(mk(1, 3'd1, 0, 3'd2, 0));
    for (int i = 0; i < 6; i++) begin
      pulse(7'b0000001, exp6[i], "R3 divide by 3");
      pulse(7'b0000000, 1'b0, "R3 idle cycle no pulse");
    end
    pulse(7'b0000001, 1'b0, "R3 partial count");
    wr(mk(0, 3'd1, 0, 3'd2, 0));
    wr(mk(1, 3'd1, 0, 3'd2, 0));
    pulse(7'b0000001, 1'b0, "R3 restart pulse 1");
    pulse(7'b0000001, 1'b0, "R3 restart pulse 2");
    pulse(7'b0000001, 1'b1, "R3 restart pulse 3");
    wr(mk(0, 3'd1, 0, 3'd2, 0));
  endtask

  task automatic t_frac;
    logic expa [6] = '{0, 1, 1, 0, 1, 1};
    logic expb [4] = '{0, 1, 0, 1};
    wr(mk(0, 3'd1, 1, 3'd2, 0));
    wr(mk(1, 3'd1, 1, 3'd2, 0));
    for (int i = 0; i < 6; i++) pulse(7'b0000001, expa[i], "R4 frac div 2");
    wr(mk(0, 3'd1, 1, 3'd2, 0));
    wr(mk(0, 3'd1, 1, 3'd3, 0));
    wr(mk(1, 3'd1, 1, 3'd3, 0));
    for (int i = 0; i < 4; i++) pulse(7'b0000001, expb[i], "R4 frac div 3");
    wr(mk(0, 3'd1, 1, 3'd3, 0));
  endtask

  task automatic t_bad_combo;
    wr(mk(0, 3'd1, 1, 3'd0, 0));
    chk("R5 invalid combo rejected", rd, PBIT | EBIT | mk(0, 3'd1, 1, 3'd3, 0));
    wr(mk(0, 3'd1, 1, 3'd3, 1));
    chk("R10 error cleared", rd, PBIT | mk(0, 3'd1, 1, 3'd3, 0));
  endtask

  task automatic t_lock_gate;
    wr(mk(1, 3'd1, 1, 3'd3, 0));
    wr(mk(1, 3'd4, 1, 3'd5, 0));
    chk("R6 config locked by gate", rd, PBIT | EBIT | mk(1, 3'd1, 1, 3'd3, 0));
    wr(mk(1, 3'd1, 1, 3'd3, 1));
    wr(mk(0, 3'd1, 1, 3'd3, 0));
    chk("R6 unlocked state", rd, PBIT | mk(0, 3'd1, 1, 3'd3, 0));
  endtask

  task automatic t_in_use;
    @(negedge clk);
    claim = 1'b1;
    @(negedge clk);
    chk("R9 in-use flag", rd & 32'h4000_0000, 32'h4000_0000);
    chk("R9 running while in use", 32'(running), 1);
    wr(mk(1, 3'd1, 1, 3'd3, 0));
    chk("R7 gate locked by in-use", rd & 32'h2000_0100, EBIT);
    wr(mk(0, 3'd2, 0, 3'd1, 1));
    chk("R6 config locked by in-use", rd & ~32'hC000_0000, EBIT | mk(0, 3'd1, 1, 3'd3, 0));
    @(negedge clk);
    claim = 1'b0;
    @(negedge clk);
    chk("R9 not running", 32'(running), 0);
    wr(mk(0, 3'd1, 1, 3'd3, 1));
    chk("R7 error cleared after release", rd, PBIT | mk(0, 3'd1, 1, 3'd3, 0));
  endtask

  task automatic t_sticky;
    wr(mk(0, 3'd1, 1, 3'd0, 0));
    wr(mk(0, 3'd3, 0, 3'd0, 0));
    chk("R10 sticky over accepted write", rd, PBIT | EBIT | mk(0, 3'd3, 0, 3'd0, 0));
    wr(mk(0, 3'd3, 1, 3'd0, 1));
    chk("R10 clear on rejected write keeps error", rd & EBIT, EBIT);
    wr(mk(0, 3'd3, 0, 3'd0, 1));
    chk("R10 cleared", rd, PBIT | mk(0, 3'd3, 0, 3'd0, 0));
  endtask

  task automatic t_absent;
    chk("R8 absent slot fields", rd_np & ~EBIT, 0);
    chk("R8 absent slot error recorded", rd_np & EBIT, EBIT);
    chk("R8 absent slot no output", 32'(clk_en_np | running_np), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_source();
    t_divide();
    t_frac();
    t_bad_combo();
    t_lock_gate();
    t_in_use();
    t_sticky();
    t_absent();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule